// File: doc/BRIEF.md
# Increment unit with flags

This block executes the add-one instruction of a byte-oriented integer core in a single registered stage. Each accepted request carries the opcode byte, the three-bit extension field taken from the addressing byte, an operand-size attribute, the current flag word and the operand value. The unit decodes which of the three instruction shapes it has been given, adds one to the operand at the right width and produces the new flag word. The carry flag passes through untouched. Overflow, sign, zero, auxiliary carry and parity are recomputed from the result.

Memory traffic, address generation, protection checks and fault delivery belong to the surrounding pipeline. The unit only reports which shape was decoded, which register a short form names, and whether the encoding was legal for this operation. Illegal encodings come back with the operand and flag word unchanged, so the caller can forward them to its fault path.

Requests enter on a valid/ready pair, and results leave on another. A request transfers on a rising edge where `in_valid` and `in_ready` are both high. The result is presented on the following cycle with `out_valid` high. It stays frozen for as long as `out_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result and a new request may therefore both transfer on one edge, which sustains one operation per cycle.

Top module: `inc_core`

## Requirements
- R1: For a legal request the result is the operand plus one, truncated to the active width (8, 16 or 32 bits); result bits above the active width are zero.
- R2: Flag bit 0 (carry) of the output equals flag bit 0 of the input for every request, legal or not.
- R3: Flag bit 11 (overflow) is set exactly when the operand, at the active width, is the largest positive signed value (0x7F, 0x7FFF or 0x7FFFFFFF).
- R4: Flag bit 4 (auxiliary carry) is set exactly when the low four bits of the operand are all ones.
- R5: Flag bit 2 (parity) is set when the low byte of the result has an even number of ones. Flag bit 7 (sign) is the top bit of the result at the active width. Flag bit 6 (zero) is set when the result at the active width is zero.
- R6: Opcode 0xFE with extension field 0 is legal, with form code 1 and width code 0 (8 bits).
- R7: Opcode 0xFF with extension field 0 is legal, with form code 2 and width code 1 (16 bits) when `in_size32` is 0 or width code 2 (32 bits) when it is 1.
- R8: Opcodes 0x40 to 0x47 are legal whatever the extension field. They give form code 3, a register number equal to the opcode's low three bits, and a width chosen by `in_size32` as in R7. All other forms report register number 0.
- R9: Any other encoding, including 0xFE or 0xFF with a nonzero extension field, gives `out_legal` 0, form code 0, width code 3, a result equal to the operand and a flag word equal to the input flag word.
- R10: Flag bits 1, 3, 5, 8, 9 and 10 of the output equal those of the input.
- R11: While `out_valid` is high and `out_ready` is low, the result and all output fields stay unchanged and `in_ready` is low. Each accepted request yields exactly one result on the next cycle.
- R12: During and right after reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_opcode | input | 8 | Opcode byte |
| in_ext | input | 3 | Extension field from the addressing byte |
| in_size32 | input | 1 | Operand-size attribute: 1 selects 32 bits, 0 selects 16 bits |
| in_flags | input | 12 | Current flag word |
| in_operand | input | 32 | Operand value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_legal | output | 1 | Encoding was legal for this operation |
| out_form | output | 2 | 0 illegal, 1 byte register/memory, 2 word/doubleword register/memory, 3 short register |
| out_reg | output | 3 | Register number of a short form, else 0 |
| out_width | output | 2 | 0 = 8, 1 = 16, 2 = 32 bits, 3 = none |
| out_result | output | 32 | Incremented value, or the operand when illegal |
| out_flags | output | 12 | Updated flag word |

## Verification
The assertions assume that every request input is at a known level whenever `in_valid` is high, and that `out_ready` is never unknown after reset. Requests are sampled only on an accepting edge. The bench drives all request fields together on the falling edge before raising `in_valid`, and holds them steady until the accepting edge has passed. It keeps `out_ready` at a defined level throughout, and lowers it only in the dedicated stall sequence.

// File: rtl/inc_pkg.sv
package inc_pkg;
  localparam int DATA_W = 32;
  localparam int FLAG_W = 12;

  localparam int CF_BIT = 0;
  localparam int PF_BIT = 2;
  localparam int AF_BIT = 4;
  localparam int ZF_BIT = 6;
  localparam int SF_BIT = 7;
  localparam int OF_BIT = 11;

  localparam logic [7:0] OPC_RM8   = 8'hFE;
  localparam logic [7:0] OPC_RMW   = 8'hFF;
  localparam logic [7:0] OPC_SHORT = 8'h40;
  localparam logic [2:0] EXT_INC   = 3'd0;

  typedef enum logic [1:0] {
    WID_8    = 2'd0,
    WID_16   = 2'd1,
    WID_32   = 2'd2,
    WID_NONE = 2'd3
  } width_e;

  typedef enum logic [1:0] {
    FORM_NONE  = 2'd0,
    FORM_RM8   = 2'd1,
    FORM_RMW   = 2'd2,
    FORM_SHORT = 2'd3
  } form_e;

  typedef struct packed {
    logic       legal;
    form_e      form;
    width_e     width;
    logic [2:0] reg_sel;
  } dec_t;

  typedef struct packed {
    dec_t              dec;
    logic [DATA_W-1:0] result;
    logic [FLAG_W-1:0] flags;
  } res_t;
endpackage

// File: rtl/inc_decode.sv
module inc_decode
  import inc_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [2:0] ext,
  input  logic       size32,
  output dec_t       dec
);
  width_e wide_sel;
  assign wide_sel = size32 ? WID_32 : WID_16;

  always_comb begin
    dec.legal   = 1'b0;
    dec.form    = FORM_NONE;
    dec.width   = WID_NONE;
    dec.reg_sel = 3'd0;
    if (opcode == OPC_RM8 && ext == EXT_INC) begin
      dec.legal = 1'b1;
      dec.form  = FORM_RM8;
      dec.width = WID_8;
    end else if (opcode == OPC_RMW && ext == EXT_INC) begin
      dec.legal = 1'b1;
      dec.form  = FORM_RMW;
      dec.width = wide_sel;
    end else if (opcode[7:3] == OPC_SHORT[7:3]) begin
      dec.legal   = 1'b1;
      dec.form    = FORM_SHORT;
      dec.width   = wide_sel;
      dec.reg_sel = opcode[2:0];
    end
  end
endmodule

// File: rtl/inc_arith.sv
module inc_arith
  import inc_pkg::*;
(
  input  logic [DATA_W-1:0] operand,
  input  width_e            width,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags_out
);
  logic [DATA_W-1:0] sum;
  logic              ovf;
  logic              sgn;

  assign sum = operand + DATA_W'(1);

  always_comb begin
    result = operand;
    ovf    = 1'b0;
    sgn    = 1'b0;
    unique case (width)
      WID_8: begin
        result = {{(DATA_W-8){1'b0}}, sum[7:0]};
        ovf    = (operand[7:0] == 8'h7F);
        sgn    = sum[7];
      end
      WID_16: begin
        result = {{(DATA_W-16){1'b0}}, sum[15:0]};
        ovf    = (operand[15:0] == 16'h7FFF);
        sgn    = sum[15];
      end
      WID_32: begin
        result = sum;
        ovf    = (operand == {1'b0, {(DATA_W-1){1'b1}}});
        sgn    = sum[DATA_W-1];
      end
      default: begin
        result = operand;
      end
    endcase
  end

  always_comb begin
    flags_out = flags_in;
    if (width != WID_NONE) begin
      flags_out[PF_BIT] = ~^result[7:0];
      flags_out[AF_BIT] = &operand[3:0];
      flags_out[ZF_BIT] = (result == '0);
      flags_out[SF_BIT] = sgn;
      flags_out[OF_BIT] = ovf;
    end
  end
endmodule

// File: rtl/inc_stage.sv
module inc_stage #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/inc_core.sv
module inc_core
  import inc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_opcode,
  input  logic [2:0]  in_ext,
  input  logic        in_size32,
  input  logic [11:0] in_flags,
  input  logic [31:0] in_operand,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_legal,
  output logic [1:0]  out_form,
  output logic [2:0]  out_reg,
  output logic [1:0]  out_width,
  output logic [31:0] out_result,
  output logic [11:0] out_flags
);
  localparam int PAY_W = $bits(res_t);

  dec_t              dec;
  logic [DATA_W-1:0] ar_result;
  logic [FLAG_W-1:0] ar_flags;
  res_t              nxt;
  res_t              cur;
  logic              in_fire;

  inc_decode u_decode (
    .opcode (in_opcode),
    .ext    (in_ext),
    .size32 (in_size32),
    .dec    (dec)
  );

  inc_arith u_arith (
    .operand   (in_operand),
    .width     (dec.width),
    .flags_in  (in_flags),
    .result    (ar_result),
    .flags_out (ar_flags)
  );

  always_comb begin
    nxt.dec    = dec;
    nxt.result = dec.legal ? ar_result : in_operand;
    nxt.flags  = dec.legal ? ar_flags  : in_flags;
  end

  inc_stage #(.PAY_W(PAY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (nxt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (cur)
  );

  assign out_legal  = cur.dec.legal;
  assign out_form   = cur.dec.form;
  assign out_reg    = cur.dec.reg_sel;
  assign out_width  = cur.dec.width;
  assign out_result = cur.result;
  assign out_flags  = cur.flags;

  assign in_fire = in_valid && in_ready;

  assert_carry_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> (out_flags[CF_BIT] == $past(in_flags[CF_BIT])));

  assert_illegal_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !dec.legal) |=> (!out_legal && out_result == $past(in_operand)
                                 && out_flags == $past(in_flags)));

  assert_ovf_min_neg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_legal && out_flags[OF_BIT]) |->
      (out_result == ((out_width == WID_8)  ? 32'h0000_0080 :
                      (out_width == WID_16) ? 32'h0000_8000 : 32'h8000_0000)));

  assert_zero_needs_aux_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_legal && out_flags[ZF_BIT]) |-> out_flags[AF_BIT]);

  assert_short_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_opcode[7:3] == OPC_SHORT[7:3]) |=>
      (out_form == FORM_SHORT && out_reg == $past(in_opcode[2:0])));

  assert_one_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);
endmodule

// File: tb/inc_core_bench.sv
module inc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_opcode;
  logic [2:0]  in_ext;
  logic        in_size32;
  logic [11:0] in_flags;
  logic [31:0] in_operand;
  logic        out_valid;
  logic        out_ready;
  logic        out_legal;
  logic [1:0]  out_form;
  logic [2:0]  out_reg;
  logic [1:0]  out_width;
  logic [31:0] out_result;
  logic [11:0] out_flags;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  inc_core u_inc_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_ext(in_ext), .in_size32(in_size32),
    .in_flags(in_flags), .in_operand(in_operand), .out_valid(out_valid),
    .out_ready(out_ready), .out_legal(out_legal), .out_form(out_form),
    .out_reg(out_reg), .out_width(out_width), .out_result(out_result),
    .out_flags(out_flags)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Drive one request, let it register, then compare against the arithmetic model.
  task automatic run(input logic [7:0] opc, input logic [2:0] ext, input logic sz,
                     input logic [11:0] fl, input logic [31:0] op);
    bit          legal;
    int          w;
    logic [1:0]  e_form, e_wid;
    logic [2:0]  e_reg;
    logic [63:0] mask;
    logic [31:0] e_res;
    logic [11:0] e_fl;
    string       dtag;
    @(negedge clk);
    in_opcode = opc; in_ext = ext; in_size32 = sz; in_flags = fl; in_operand = op;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    legal = 1'b1; e_reg = 3'd0; w = 0; dtag = "R9";
    if (opc == 8'hFE && ext == 3'd0) begin
      w = 8; e_form = 2'd1; e_wid = 2'd0; dtag = "R6";
    end else if (opc == 8'hFF && ext == 3'd0) begin
      w = sz ? 32 : 16; e_form = 2'd2; e_wid = sz ? 2'd2 : 2'd1; dtag = "R7";
    end else if (opc >= 8'h40 && opc <= 8'h47) begin
      w = sz ? 32 : 16; e_form = 2'd3; e_wid = sz ? 2'd2 : 2'd1; e_reg = opc[2:0];
      dtag = "R8";
    end else begin
      legal = 1'b0; e_form = 2'd0; e_wid = 2'd3;
    end
    if (legal) begin
      mask  = (64'd1 << w) - 64'd1;
      e_res = 32'((64'(op) + 64'd1) & mask);
      e_fl  = fl;
      e_fl[2]  = ($countones(e_res[7:0]) % 2) == 0;
      e_fl[4]  = (op[3:0] == 4'hF);
      e_fl[6]  = (e_res == 32'd0);
      e_fl[7]  = e_res[w-1];
      e_fl[11] = ((64'(op) & mask) == (mask >> 1));
    end else begin
      e_res = op;
      e_fl  = fl;
    end
    chk(out_valid === 1'b1, "R11 valid", 32'(out_valid), 32'd1);
    chk(out_legal === legal, {dtag, " legal"}, 32'(out_legal), 32'(legal));
    chk(out_form === e_form, {dtag, " form"}, 32'(out_form), 32'(e_form));
    chk(out_width === e_wid, {dtag, " width"}, 32'(out_width), 32'(e_wid));
    chk(out_reg === e_reg, "R8 reg", 32'(out_reg), 32'(e_reg));
    chk(out_result === e_res, legal ? "R1 result" : "R9 result", out_result, e_res);
    chk(out_flags[0] === fl[0], "R2 carry", 32'(out_flags[0]), 32'(fl[0]));
    chk(out_flags[11] === e_fl[11], "R3 overflow", 32'(out_flags[11]), 32'(e_fl[11]));
    chk(out_flags[4] === e_fl[4], "R4 auxcarry", 32'(out_flags[4]), 32'(e_fl[4]));
    chk(out_flags[7:6] === e_fl[7:6] && out_flags[2] === e_fl[2], "R5 sign/zero/parity",
        32'(out_flags), 32'(e_fl));
    chk((out_flags & 12'h72A) === (fl & 12'h72A), "R10 other bits",
        32'(out_flags), 32'(fl));
    if (!legal)
      chk(out_flags === fl, "R9 flags", 32'(out_flags), 32'(fl));
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R11 watchdog act=timeout exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_opcode = 8'h00; in_ext = 3'd0; in_size32 = 1'b0; in_flags = 12'h000;
    in_operand = 32'h0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R12 reset valid", 32'(out_valid), 32'd0);
    chk(in_ready === 1'b1, "R12 reset ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R12 after reset valid", 32'(out_valid), 32'd0);

    // R6: every byte operand, flag word varied
    for (int i = 0; i < 256; i++)
      run(8'hFE, 3'd0, i[0], 12'(i * 37), 32'(i) | 32'hABCD_0000);

    // R7: every 16-bit operand through the register/memory word form
    for (int i = 0; i < 65536; i++)
      run(8'hFF, 3'd0, 1'b0, 12'(i ^ (i >> 5)), 32'(i) | 32'h5A00_0000);

    // R7 doubleword corners
    for (int k = 0; k < 16; k++) begin
      logic [31:0] v;
      case (k % 8)
        0: v = 32'h7FFF_FFFF;
        1: v = 32'hFFFF_FFFF;
        2: v = 32'h0000_0000;
        3: v = 32'h8000_0000;
        4: v = 32'h0000_FFFF;
        5: v = 32'h7FFF_FFFE;
        6: v = 32'h1234_567F;
        default: v = 32'hFFFF_FFFE;
      endcase
      run(8'hFF, 3'd0, 1'b1, (k < 8) ? 12'hFFF : 12'h000, v);
    end

    // R8: short register forms at both widths, extension field ignored
    for (int r = 0; r < 8; r++) begin
      run(8'h40 + 8'(r), 3'(r), 1'b0, 12'h001, 32'h0000_7FFF);
      run(8'h40 + 8'(r), 3'(7 - r), 1'b0, 12'h000, 32'h0000_FFFF);
      run(8'h40 + 8'(r), 3'(r), 1'b1, 12'hF0F, 32'h7FFF_FFFF);
      run(8'h40 + 8'(r), 3'd0, 1'b1, 12'h8C5, 32'hFFFF_FFFF);
      run(8'h40 + 8'(r), 3'd5, 1'b1, 12'h3A2, 32'(r * 4099));
    end

    // R9: extension field nonzero on both register/memory opcodes
    for (int e = 1; e < 8; e++) begin
      run(8'hFE, 3'(e), 1'b0, 12'hFFF, 32'h0000_00FF);
      run(8'hFF, 3'(e), 1'b1, 12'h555, 32'h7FFF_FFFF);
    end

    // R9: sweep all opcodes
    for (int o = 0; o < 256; o++)
      run(8'(o), 3'd0, o[1], 12'(o * 11), 32'h0F0F_7F0F + 32'(o));

    // R11: stall holds the result; a queued request lands on release
    @(negedge clk);
    out_ready = 1'b0;
    in_opcode = 8'hFE; in_ext = 3'd0; in_size32 = 1'b0; in_flags = 12'h000;
    in_operand = 32'h0000_0010; in_valid = 1'b1;
    @(negedge clk);
    in_operand = 32'h0000_0020;
    chk(out_valid === 1'b1 && out_result === 32'h11, "R11 first", out_result, 32'h11);
    chk(in_ready === 1'b0, "R11 ready low", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk(out_result === 32'h11, "R11 hold", out_result, 32'h11);
    chk(out_valid === 1'b1, "R11 hold valid", 32'(out_valid), 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1 && out_result === 32'h21, "R11 second", out_result, 32'h21);
    @(negedge clk);
    chk(out_valid === 1'b0, "R11 drained", 32'(out_valid), 32'd0);

    finished = 1;
    summary();
    $finish;
  end
endmodule